// File: doc/BRIEF.md
# Cascaded Readout Sample Demultiplexer

Two 64-channel front ends are chained: the start output of the first feeds the start input of the second. Each device has two output drivers. All four drivers share one ADC, which delivers a single stream of samples. The second device starts one clock after the first, so the stream repeats a fixed four-step pattern. In that pattern the two devices alternate within each driver pair, beginning with driver 1 of the first device. The pattern holds only when the front ends run in sequential mode. This block takes that stream and splits it into four tagged lanes, one per device and driver pair, which cover all 128 channels.

A start strobe arms the block and aligns the rotation. After the strobe, each accepted sample is written into its lane register along with a per-driver channel index. That lane's valid bit is raised for one cycle. Gaps in the sample-valid strobe stall the rotation and do not skip a phase. A single-cycle frame pulse marks the 128th sample routed after a start.

Top module: `casc_demux_top`

## Requirements
- R1: After reset, every bit of `laneValid`, `laneData`, `laneIdx` and `frameDone` is 0.
- R2: Samples that arrive before the first `startIn` since reset are dropped and raise no lane valid.
- R3: A cycle with `startIn` high accepts no sample, even if `smpValid` is high. The next valid sample after it is phase 0.
- R4: Lane number = 2*device + driver, with the first device as device 0. Phase 0 goes to lane 1, phase 1 to lane 3, phase 2 to lane 0 and phase 3 to lane 2. The phase then wraps to 0.
- R5: The phase advances only on accepted samples. Cycles without `smpValid` leave it unchanged.
- R6: An accepted sample appears in the `laneData` slot of its lane on the clock edge that accepts it. `laneValid` then has exactly that one bit set for one cycle.
- R7: All four samples of rotation k since the last start carry `laneIdx` = k mod 32, so the index wraps after 32 samples per driver.
- R8: `frameDone` is a one-cycle pulse, raised together with the lane valid of the 128th accepted sample after a start, and again every further 128 samples.
- R9: A start in the middle of a frame resets the phase, the channel index and the frame count.
- R10: A lane's `laneData` and `laneIdx` hold their values while no sample is routed to that lane.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startIn | input | 1 | Start strobe of the first device; arms and realigns the rotation |
| smpValid | input | 1 | ADC sample strobe |
| smpData | input | DATA_W | ADC sample |
| laneValid | output | 4 | One-hot: the lane that received a sample this cycle |
| laneData | output | 4 x DATA_W | Last sample routed to each lane |
| laneIdx | output | 4 x 5 | Channel index of the last sample routed to each lane |
| frameDone | output | 1 | Pulse with the 128th sample of a frame |

## Verification
The main function is tested with three input patterns.
- A continuous stream tests the plain four-step rotation and the index wrap.
- A stream with periodic valid gaps tests whether the phase counts samples or cycles. A design that counts cycles routes to the wrong lanes.
- A start issued mid-frame, and a start that coincides with a valid sample, test whether realignment clears the phase, the index and the frame count, and whether it discards the coincident sample.

Samples sent before any start test whether the block is armed.

// File: rtl/casc_demux_pkg.sv
package casc_demux_pkg;
  localparam int DEV_COUNT    = 2;
  localparam int DRV_PER_DEV  = 2;
  localparam int CHAN_PER_DEV = 64;
  localparam int LANES        = DEV_COUNT * DRV_PER_DEV;
  localparam int CHAN_PER_DRV = CHAN_PER_DEV / DRV_PER_DEV;
  localparam int IDX_W        = $clog2(CHAN_PER_DRV);
  localparam int PHASE_W      = $clog2(LANES);
  localparam int FRAME_LEN    = DEV_COUNT * CHAN_PER_DEV;
  localparam int CNT_W        = $clog2(FRAME_LEN);

  typedef struct packed {
    logic             accept;
    logic [LANES-1:0] laneSel;
    logic             clearIdx;
    logic             bumpIdx;
    logic             frameEnd;
  } ctrl_strobe_t;
endpackage

// File: rtl/casc_demux_ctrl.sv
module casc_demux_ctrl
  import casc_demux_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         startIn,
  input  logic         smpValid,
  output ctrl_strobe_t strb
);
  logic               armed;
  logic [PHASE_W-1:0] phase;
  logic [CNT_W-1:0]   sampleCnt;
  logic [LANES-1:0]   laneHit;
  logic               lastPhase;
  logic               lastSample;
  logic               take;

  // Phase that feeds each lane: devices alternate inside a driver pair,
  // upper driver first.
  for (genvar g = 0; g < LANES; g++) begin : gLane
    localparam int DEV = g / DRV_PER_DEV;
    localparam int DRV = g % DRV_PER_DEV;
    localparam int PH  = (DRV_PER_DEV - 1 - DRV) * DEV_COUNT + DEV;
    assign laneHit[g] = (phase == PHASE_W'(PH));
  end

  assign take       = armed && smpValid && !startIn;
  assign lastPhase  = (phase == PHASE_W'(LANES - 1));
  assign lastSample = (sampleCnt == CNT_W'(FRAME_LEN - 1));

  always_comb begin
    strb          = '0;
    strb.clearIdx = startIn;
    if (take) begin
      strb.accept   = 1'b1;
      strb.laneSel  = laneHit;
      strb.bumpIdx  = lastPhase;
      strb.frameEnd = lastSample;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      armed     <= 1'b0;
      phase     <= '0;
      sampleCnt <= '0;
    end else if (startIn) begin
      armed     <= 1'b1;
      phase     <= '0;
      sampleCnt <= '0;
    end else if (take) begin
      phase     <= lastPhase ? '0 : phase + 1'b1;
      sampleCnt <= lastSample ? '0 : sampleCnt + 1'b1;
    end
  end

  // R2
  no_accept_unarmed_chk: assert property (@(posedge clk) disable iff (!rstN)
    !armed |-> !strb.accept);

  // R3
  start_restart_chk: assert property (@(posedge clk) disable iff (!rstN)
    startIn |=> (armed && phase == '0 && sampleCnt == '0));

  // R4
  lane_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.accept |-> ($countones(strb.laneSel) == 1));

  // R5
  phase_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!startIn && !smpValid) |=> $stable(phase));
endmodule

// File: rtl/casc_demux_dp.sv
module casc_demux_dp
  import casc_demux_pkg::*;
#(
  parameter int DATA_W = 12
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  ctrl_strobe_t                  strb,
  input  logic [DATA_W-1:0]             smpData,
  output logic [LANES-1:0]              laneValid,
  output logic [LANES-1:0][DATA_W-1:0]  laneData,
  output logic [LANES-1:0][IDX_W-1:0]   laneIdx,
  output logic                          frameDone
);
  logic [IDX_W-1:0]  rotIdx;
  logic [DATA_W-1:0] dataQ [LANES];
  logic [IDX_W-1:0]  idxQ  [LANES];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rotIdx <= '0;
    end else if (strb.clearIdx) begin
      rotIdx <= '0;
    end else if (strb.bumpIdx) begin
      rotIdx <= (rotIdx == IDX_W'(CHAN_PER_DRV - 1)) ? '0 : rotIdx + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      laneValid <= '0;
      frameDone <= 1'b0;
    end else begin
      laneValid <= strb.accept ? strb.laneSel : '0;
      frameDone <= strb.frameEnd;
    end
  end

  for (genvar g = 0; g < LANES; g++) begin : gReg
    always_ff @(posedge clk) begin
      if (!rstN) begin
        dataQ[g] <= '0;
        idxQ[g]  <= '0;
      end else if (strb.accept && strb.laneSel[g]) begin
        dataQ[g] <= smpData;
        idxQ[g]  <= rotIdx;
      end
    end
    assign laneData[g] = dataQ[g];
    assign laneIdx[g]  = idxQ[g];
  end

  // R6
  valid_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(laneValid));

  // R8
  done_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    frameDone |=> !frameDone);

  // R8
  done_with_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    frameDone |-> (|laneValid));

  // R7
  idx_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.bumpIdx && !strb.clearIdx) |=> (rotIdx != $past(rotIdx)));

  // R10
  lane_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strb.accept |=> ($stable(laneData) && $stable(laneIdx)));
endmodule

// File: rtl/casc_demux_top.sv
module casc_demux_top
  import casc_demux_pkg::*;
#(
  parameter int DATA_W = 12
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         startIn,
  input  logic                         smpValid,
  input  logic [DATA_W-1:0]            smpData,
  output logic [LANES-1:0]             laneValid,
  output logic [LANES-1:0][DATA_W-1:0] laneData,
  output logic [LANES-1:0][IDX_W-1:0]  laneIdx,
  output logic                         frameDone
);
  ctrl_strobe_t strb;

  casc_demux_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .startIn  (startIn),
    .smpValid (smpValid),
    .strb     (strb)
  );

  casc_demux_dp #(.DATA_W(DATA_W)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .smpData   (smpData),
    .laneValid (laneValid),
    .laneData  (laneData),
    .laneIdx   (laneIdx),
    .frameDone (frameDone)
  );
endmodule

// File: tb/casc_demux_top_tb_top.sv
`timescale 1ns/1ps
module casc_demux_top_tb_top;
  localparam int DW = 12;

  typedef struct {
    int          lane;
    logic [DW-1:0] data;
    int          idx;
    bit          done;
  } exp_t;

  logic                 clk = 1'b0;
  logic                 rstN = 1'b0;
  logic                 startIn = 1'b0;
  logic                 smpValid = 1'b0;
  logic [DW-1:0]        smpData = '0;
  logic [3:0]           laneValid;
  logic [3:0][DW-1:0]   laneData;
  logic [3:0][4:0]      laneIdx;
  logic                 frameDone;

  int checks = 0;
  int errors = 0;
  int sawCount = 0;
  int doneSeen = 0;
  int expDone = 0;
  bit running = 1'b0;
  bit finished = 1'b0;

  exp_t q[$];
  bit  bArmed = 1'b0;
  int  bPhase = 0;
  int  bRot = 0;
  int  bCnt = 0;
  logic [DW-1:0] lastData [4] = '{default: '0};
  int  lastIdx [4] = '{default: 0};

  always #10 clk = ~clk;

  casc_demux_top #(.DATA_W(DW)) dut_i (
    .clk(clk), .rstN(rstN), .startIn(startIn), .smpValid(smpValid),
    .smpData(smpData), .laneValid(laneValid), .laneData(laneData),
    .laneIdx(laneIdx), .frameDone(frameDone)
  );

  task automatic check(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // R4 lane map: phase 0->1, 1->3, 2->0, 3->2
  function automatic int laneOf(int ph);
    case (ph)
      0: return 1;
      1: return 3;
      2: return 0;
      default: return 2;
    endcase
  endfunction

  task automatic drive(bit st, bit v, logic [DW-1:0] d);
    exp_t e;
    @(posedge clk);
    #15;
    startIn = st; smpValid = v; smpData = d;
    if (st) begin
      bArmed = 1'b1; bPhase = 0; bRot = 0; bCnt = 0;
    end else if (bArmed && v) begin
      e.lane = laneOf(bPhase); e.data = d; e.idx = bRot; e.done = (bCnt == 127);
      q.push_back(e);
      lastData[e.lane] = d; lastIdx[e.lane] = bRot;
      if (e.done) expDone++;
      bCnt = (bCnt + 1) % 128;
      if (bPhase == 3) begin bPhase = 0; bRot = (bRot + 1) % 32; end
      else bPhase++;
    end
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) drive(1'b0, 1'b0, '0);
  endtask

  // Monitor: pops the scoreboard whenever a lane valid appears
  always @(negedge clk) begin
    int   n;
    int   ln;
    exp_t e;
    if (running) begin
      n = $countones(laneValid);
      if (frameDone) doneSeen++;
      if (n > 1) check(1'b0, "R6", "lane valid count", n, 1);
      if (frameDone && n == 0) check(1'b0, "R8", "done without sample", 0, 1);
      if (n == 1) begin
        sawCount++;
        ln = 0;
        for (int l = 0; l < 4; l++) if (laneValid[l]) ln = l;
        if (q.size() == 0) begin
          check(1'b0, "R2", "unexpected lane sample", ln, -1);
        end else begin
          e = q.pop_front();
          check(ln == e.lane, "R4", "lane", ln, e.lane);
          check(laneData[ln] == e.data, "R6", "data", int'(laneData[ln]), int'(e.data));
          check(int'(laneIdx[ln]) == e.idx, "R7", "channel index", int'(laneIdx[ln]), e.idx);
          check(frameDone == e.done, "R8", "frame pulse", int'(frameDone), int'(e.done));
        end
      end
    end
  end

  initial begin
    #(20 * 200000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #15 rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(laneValid == '0, "R1", "laneValid", int'(laneValid), 0);
    check(frameDone == 1'b0, "R1", "frameDone", int'(frameDone), 0);
    check(laneData == '0, "R1", "laneData nonzero", 1, 0);
    check(laneIdx == '0, "R1", "laneIdx nonzero", 1, 0);
    running = 1'b1;

    // R2: samples before any start are dropped
    for (int i = 0; i < 5; i++) drive(1'b0, 1'b1, DW'(100 + i));
    idle(2);
    check(sawCount == 0, "R2", "samples routed before start", sawCount, 0);

    // R3: start with a coincident valid sample
    drive(1'b1, 1'b1, DW'(12'hABC));
    idle(2);
    check(sawCount == 0, "R3", "coincident sample routed", sawCount, 0);

    // R5: gapped stream across a full frame
    for (int i = 0; i < 150; i++) begin
      if (i % 7 == 3) idle(1 + (i % 3));
      drive(1'b0, 1'b1, DW'(i * 37 + 5));
    end
    // back-to-back stream, crosses more frames and index wraps (R7, R8)
    for (int i = 0; i < 300; i++) drive(1'b0, 1'b1, DW'(i * 91 + 3));
    idle(2);

    // R9: restart in mid-frame
    for (int i = 0; i < 10; i++) drive(1'b0, 1'b1, DW'(i + 2000));
    drive(1'b1, 1'b0, '0);
    for (int i = 0; i < 133; i++) drive(1'b0, 1'b1, DW'(i * 13 + 700));
    idle(4);

    // R10: lanes hold their last values while idle
    for (int l = 0; l < 4; l++) begin
      check(laneData[l] == lastData[l], "R10", "held data", int'(laneData[l]), int'(lastData[l]));
      check(int'(laneIdx[l]) == lastIdx[l], "R10", "held index", int'(laneIdx[l]), lastIdx[l]);
    end

    check(q.size() == 0, "R6", "samples never produced", q.size(), 0);
    check(doneSeen == expDone, "R8", "frame pulse count", doneSeen, expDone);
    running = 1'b0;
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule